// File: doc/BRIEF.md
# Key-Locked Configurable Lookup Table

This block is a lookup table of up to six physical inputs whose content memory can hold two functions at once. One input index, picked when the table is configured, carries a key bit instead of a data signal. The key bit chooses between a genuine function and a decoy function stored in the otherwise unused half of the content bits. If the key sits on the highest used input, the two functions occupy the lower and upper halves of the memory. If it sits on a lower input, their entries alternate.

Configuration arrives one bit per clock on a serial port while a load strobe is high. The shifted word carries the 64 content bits, a key-placement field and a used-input count. The word is committed as a whole once the strobe drops, so the running function never sees a half-loaded table. During operation the table address is formed from the function inputs, with the key bit substituted at its index and the unused inputs forced low. The selected content bit is registered on the output. A table that uses every input and has no key behaves as an ordinary lookup.

Top module: `klut_keyed_lut`

## Requirements
- R1: A synchronous reset clears the output register, the shift chain and the active configuration to zero. After reset `lut_out` and `config_error` are 0 for every input pattern.
- R2: With a used-input count of 6 and key field 0, `lut_out` equals content bit number `fn_in`, where `fn_in[i]` is address bit i.
- R3: The configuration word is 70 bits, shifted in most significant bit first while `cfg_load` is high. Its layout is {content[63:0], key field[2:0], used count[2:0]}, so the first bit shifted is content bit 63 and the last is bit 0 of the used count. When `cfg_load` is low the chain holds its value.
- R4: The shifted word becomes active at the first rising edge where `cfg_load` is sampled low after being high. Until that edge, including the whole time bits are being shifted, the output follows the previous configuration.
- R5: A key field value p from 1 to 6 puts the key at input p-1: address bit p-1 takes `key_in` and `fn_in[p-1]` is disregarded. Key field 0 means the table has no key input.
- R6: The used-input count includes the key. Address bits at index equal to or above the count are 0, so function inputs at those indices have no effect on `lut_out`.
- R7: With the key on the top used input, key 0 selects the lower half and key 1 the upper half. Example: count 3, key field 3, and content[7:0] holding 0,1,1,0,0,0,0,1 in index order {key, X, Y}. Here X is `fn_in[1]` and Y is `fn_in[0]`. This gives X XOR Y with key 0 and X AND Y with key 1. With the key on input 0, the two functions interleave on even and odd addresses.
- R8: A used count above 6, or a key field above the used count, is invalid. While the active configuration is invalid, `config_error` is 1 and the next registered `lut_out` is 0.
- R9: `lut_out` is registered. A change on `fn_in` or `key_in` shows at the output only after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Shift strobe for the configuration chain |
| cfg_bit | input | 1 | Serial configuration data, most significant bit first |
| fn_in | input | 6 | Function inputs, bit i drives address bit i |
| key_in | input | 1 | Key bit routed to the configured key index |
| lut_out | output | 1 | Registered table output |
| config_error | output | 1 | Active configuration is invalid |

## Verification
Two functions can act on the same edge. One is the commit of a freshly shifted word, and the other is the registered lookup through the old word. The bench holds the function inputs steady through a full reload. It checks that the output sampled just after the commit edge still shows the old table's value, and that the new function appears only one edge later. A second overlap arises when the inputs change on the very cycle the strobe falls. That case is judged by a behavioural reference model that tracks the shift history. The model applies the commit after forming the output for that edge, and it is compared with the design on every clock.

// File: rtl/klut_pkg.sv
package klut_pkg;

   // Read-path structure for the content memory
   typedef enum logic {
      RD_TREE  = 1'b0,
      RD_INDEX = 1'b1
   } klut_read_e;

   // Invalid when the count exceeds the physical inputs or the key lies outside the used span
   function automatic logic cfg_invalid(input logic [7:0] key_field,
                                        input logic [7:0] use_cnt,
                                        input int         num_in);
      return (int'(use_cnt) > num_in) || (key_field > use_cnt);
   endfunction

endpackage

// File: rtl/klut_cfg_chain.sv
module klut_cfg_chain #(
   parameter int NUM_IN  = 6,
   parameter int FIELD_W = 3
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          cfg_load,
   input  logic                          cfg_bit,
   output logic [(1<<NUM_IN)-1:0]        content,
   output logic [FIELD_W-1:0]            key_field,
   output logic [FIELD_W-1:0]            use_cnt
);
   localparam int CONTENT_W = 1 << NUM_IN;
   localparam int CHAIN_W   = CONTENT_W + 2*FIELD_W;

   logic [CHAIN_W-1:0] shadow_q;
   logic [CHAIN_W-1:0] active_q;
   logic               load_d;

   always_ff @(posedge clk) begin
      if (rst) begin
         shadow_q <= '0;
         active_q <= '0;
         load_d   <= 1'b0;
      end else begin
         load_d <= cfg_load;
         if (cfg_load)
            shadow_q <= {shadow_q[CHAIN_W-2:0], cfg_bit};
         if (!cfg_load && load_d)
            active_q <= shadow_q;
      end
   end

   assign content   = active_q[CHAIN_W-1 -: CONTENT_W];
   assign key_field = active_q[2*FIELD_W-1 -: FIELD_W];
   assign use_cnt   = active_q[FIELD_W-1:0];

   // R4
   active_hold_chk: assert property (@(posedge clk) disable iff (rst)
      cfg_load |=> $stable(active_q));

   // R4
   commit_copy_chk: assert property (@(posedge clk) disable iff (rst)
      (!cfg_load && load_d) |=> (active_q == $past(shadow_q)));

   // R3
   shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !cfg_load |=> $stable(shadow_q));

endmodule

// File: rtl/klut_addr_gen.sv
module klut_addr_gen #(
   parameter int NUM_IN  = 6,
   parameter int FIELD_W = 3
) (
   input  logic [NUM_IN-1:0]  fn_in,
   input  logic               key_in,
   input  logic [FIELD_W-1:0] key_field,
   input  logic [FIELD_W-1:0] use_cnt,
   output logic [NUM_IN-1:0]  addr
);
   for (genvar i = 0; i < NUM_IN; i++) begin : g_bit
      logic in_use;
      logic is_key;
      assign in_use  = use_cnt > FIELD_W'(i);
      assign is_key  = (key_field != '0) && (key_field == FIELD_W'(i + 1));
      assign addr[i] = in_use ? (is_key ? key_in : fn_in[i]) : 1'b0;
   end

endmodule

// File: rtl/klut_out_stage.sv
module klut_out_stage
   import klut_pkg::*;
#(
   parameter int         NUM_IN  = 6,
   parameter klut_read_e RD_MODE = RD_TREE
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic [(1<<NUM_IN)-1:0] content,
   input  logic [NUM_IN-1:0]      addr,
   input  logic                   cfg_bad,
   output logic                   lut_q
);
   localparam int CONTENT_W = 1 << NUM_IN;

   logic sel_bit;

   if (RD_MODE == RD_TREE) begin : g_tree
      for (genvar l = 0; l < NUM_IN; l++) begin : g_lvl
         localparam int W = CONTENT_W >> (l + 1);
         logic [W-1:0] node;
         for (genvar j = 0; j < W; j++) begin : g_node
            if (l == 0) begin : g_leaf
               assign node[j] = addr[0] ? content[2*j+1] : content[2*j];
            end else begin : g_inner
               assign node[j] = addr[l] ? g_lvl[l-1].node[2*j+1] : g_lvl[l-1].node[2*j];
            end
         end
      end
      assign sel_bit = g_lvl[NUM_IN-1].node[0];
   end else begin : g_index
      assign sel_bit = content[addr];
   end

   always_ff @(posedge clk) begin
      if (rst)
         lut_q <= 1'b0;
      else
         lut_q <= cfg_bad ? 1'b0 : sel_bit;
   end

   // R8
   bad_cfg_zero_chk: assert property (@(posedge clk) disable iff (rst)
      cfg_bad |=> !lut_q);

endmodule

// File: rtl/klut_keyed_lut.sv
module klut_keyed_lut
   import klut_pkg::*;
#(
   parameter int         NUM_IN  = 6,
   parameter int         FIELD_W = 3,
   parameter klut_read_e RD_MODE = RD_TREE
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cfg_load,
   input  logic              cfg_bit,
   input  logic [NUM_IN-1:0] fn_in,
   input  logic              key_in,
   output logic              lut_out,
   output logic              config_error
);
   localparam int CONTENT_W = 1 << NUM_IN;

   if (NUM_IN < 1 || NUM_IN >= (1 << FIELD_W)) begin : g_bad_width
      $error("klut_keyed_lut: NUM_IN must be at least 1 and fit the field width");
   end
   if (FIELD_W > 8) begin : g_bad_field
      $error("klut_keyed_lut: FIELD_W above 8 is not supported");
   end

   logic [CONTENT_W-1:0] content;
   logic [FIELD_W-1:0]   key_field;
   logic [FIELD_W-1:0]   use_cnt;
   logic [NUM_IN-1:0]    addr;
   logic                 cfg_bad;

   klut_cfg_chain #(.NUM_IN(NUM_IN), .FIELD_W(FIELD_W)) u_chain (
      .clk       (clk),
      .rst       (rst),
      .cfg_load  (cfg_load),
      .cfg_bit   (cfg_bit),
      .content   (content),
      .key_field (key_field),
      .use_cnt   (use_cnt)
   );

   klut_addr_gen #(.NUM_IN(NUM_IN), .FIELD_W(FIELD_W)) u_addr (
      .fn_in     (fn_in),
      .key_in    (key_in),
      .key_field (key_field),
      .use_cnt   (use_cnt),
      .addr      (addr)
   );

   assign cfg_bad      = cfg_invalid(8'(key_field), 8'(use_cnt), NUM_IN);
   assign config_error = cfg_bad;

   klut_out_stage #(.NUM_IN(NUM_IN), .RD_MODE(RD_MODE)) u_out (
      .clk     (clk),
      .rst     (rst),
      .content (content),
      .addr    (addr),
      .cfg_bad (cfg_bad),
      .lut_q   (lut_out)
   );

   // R5
   key_route_chk: assert property (@(posedge clk) disable iff (rst)
      (key_field != '0 && key_field <= use_cnt && int'(use_cnt) <= NUM_IN)
         |-> (addr[key_field - 1'b1] == key_in));

   // R6
   unused_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (int'(use_cnt) < NUM_IN) |-> ((addr >> use_cnt) == '0));

endmodule

// File: tb/klut_keyed_lut_bench.sv
`timescale 1ns/1ps
module klut_keyed_lut_bench;
   localparam int NI = 6;
   localparam int CW = 64;
   localparam int KW = 70;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic cfg_load = 1'b0;
   logic cfg_bit = 1'b0;
   logic [NI-1:0] fn_in = '0;
   logic key_in = 1'b0;
   logic lut_out;
   logic config_error;

   int checks = 0;
   int fails = 0;
   string cur_req = "R1";

   always #4 clk = ~clk;

   klut_keyed_lut u_klut_keyed_lut (
      .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_bit(cfg_bit),
      .fn_in(fn_in), .key_in(key_in), .lut_out(lut_out), .config_error(config_error)
   );

   // behavioural reference model
   bit q_hist[$];
   logic [CW-1:0] m_content;
   int m_kf, m_cnt;
   logic m_out, m_prev_load;

   function automatic logic m_bad();
      return (m_cnt > 6) || (m_kf > m_cnt);
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         m_content = '0; m_kf = 0; m_cnt = 0; m_out = 1'b0; m_prev_load = 1'b0;
         q_hist.delete();
         for (int j = 0; j < KW; j++) q_hist.push_back(1'b0);
      end else begin
         int a;
         a = 0;
         for (int i = 0; i < NI; i++) begin
            int b;
            if (i >= m_cnt) b = 0;
            else if (m_kf != 0 && i == m_kf - 1) b = key_in;
            else b = fn_in[i];
            a += b << i;
         end
         m_out = m_bad() ? 1'b0 : m_content[a];
         if (cfg_load) begin
            q_hist.push_back(cfg_bit);
            void'(q_hist.pop_front());
         end else if (m_prev_load) begin
            logic [KW-1:0] w;
            for (int j = 0; j < KW; j++) w[KW-1-j] = q_hist[j];
            m_content = w[KW-1 -: CW];
            m_kf = int'(w[5:3]);
            m_cnt = int'(w[2:0]);
         end
         m_prev_load = cfg_load;
      end
   end

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!rst) begin
         chk({cur_req, " model out"}, lut_out, m_out);
         chk({cur_req, " model err"}, config_error, m_bad());
      end
   end

   task automatic apply(input logic [NI-1:0] f, input logic k);
      @(negedge clk);
      fn_in = f; key_in = k;
      @(negedge clk);
   endtask

   task automatic load_cfg(input logic [CW-1:0] c, input logic [2:0] kf, input logic [2:0] cnt);
      logic [KW-1:0] w;
      w = {c, kf, cnt};
      for (int i = KW-1; i >= 0; i--) begin
         @(negedge clk);
         cfg_load = 1'b1; cfg_bit = w[i];
      end
      @(negedge clk);
      cfg_load = 1'b0;
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [CW-1:0] pat;
      logic [CW-1:0] ilv;
      pat = 64'hF0E1_D2C3_B4A5_9687;
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;

      // R1 reset state
      @(negedge clk);
      chk("R1 out after reset", lut_out, 1'b0);
      chk("R1 err after reset", config_error, 1'b0);
      apply(6'h3F, 1'b1);
      chk("R1 cleared content", lut_out, 1'b0);

      // R2 R3 full table, no key
      cur_req = "R2";
      load_cfg(pat, 3'd0, 3'd6);
      foreach (pat[a]) begin
         apply(6'(a), a[0]);
         chk("R2 R3 full table lookup", lut_out, pat[a]);
      end

      // R9 latency
      cur_req = "R9";
      apply(6'd3, 1'b0);
      @(negedge clk);
      fn_in = 6'd0;
      #2;
      chk("R9 output holds before edge", lut_out, pat[3]);
      @(negedge clk);
      chk("R9 output after edge", lut_out, pat[0]);

      // R4 reload with steady inputs; R7 top-key split
      cur_req = "R4";
      apply(6'h3F, 1'b0);
      load_cfg({56'h0, 8'h86}, 3'd3, 3'd3);
      chk("R4 old table on commit edge", lut_out, pat[63]);
      @(negedge clk);
      chk("R4 new table next edge", lut_out, 1'b1 ^ 1'b1);

      cur_req = "R7";
      for (int k = 0; k < 2; k++)
         for (int x = 0; x < 2; x++)
            for (int y = 0; y < 2; y++) begin
               logic e;
               e = k[0] ? (x[0] & y[0]) : (x[0] ^ y[0]);
               apply({3'b111, ~k[0], x[0], y[0]}, k[0]);
               chk("R7 R5 top key selects half", lut_out, e);
            end

      // R5 interleaved key at input 0
      cur_req = "R5";
      ilv = '1;
      for (int x = 0; x < 2; x++)
         for (int y = 0; y < 2; y++)
            for (int k = 0; k < 2; k++)
               ilv[x*4 + y*2 + k] = k[0] ? ~(x[0] & y[0]) : (x[0] | y[0]);
      load_cfg(ilv, 3'd1, 3'd3);
      for (int k = 0; k < 2; k++)
         for (int x = 0; x < 2; x++)
            for (int y = 0; y < 2; y++) begin
               logic e;
               e = k[0] ? ~(x[0] & y[0]) : (x[0] | y[0]);
               apply({3'b101, x[0], y[0], ~k[0]}, k[0]);
               chk("R5 interleaved key", lut_out, e);
            end

      // R6 unused inputs ignored
      cur_req = "R6";
      load_cfg(64'hFFFF_FFFF_FFFF_FFF6, 3'd0, 3'd2);
      for (int hi = 0; hi < 16; hi += 5)
         for (int v = 0; v < 4; v++) begin
            apply({4'(hi), 2'(v)}, 1'b1);
            chk("R6 upper inputs ignored", lut_out, v[1] ^ v[0]);
         end

      // R8 invalid configurations
      cur_req = "R8";
      load_cfg('1, 3'd5, 3'd3);
      chk("R8 key beyond count flags", config_error, 1'b1);
      apply(6'd1, 1'b0);
      chk("R8 key beyond count output", lut_out, 1'b0);
      load_cfg('1, 3'd0, 3'd7);
      chk("R8 count above six flags", config_error, 1'b1);
      apply(6'd5, 1'b1);
      chk("R8 count above six output", lut_out, 1'b0);
      load_cfg('1, 3'd3, 3'd3);
      chk("R8 key at count boundary valid", config_error, 1'b0);
      apply(6'd2, 1'b0);
      chk("R8 boundary output", lut_out, 1'b1);

      // R1 reset clears configuration
      cur_req = "R1";
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      #1 rst = 1'b0;
      apply(6'd7, 1'b1);
      chk("R1 reset clears config", lut_out, 1'b0);
      chk("R1 reset clears error", config_error, 1'b0);

      finish_run();
   end
endmodule